// File: doc/BRIEF.md
# Drum Controller Programmed-I/O Decoder

This block sits between the processor's programmed-I/O bus and the transfer engine of a serial drum controller. One controller answers on three consecutive device-select codes. Each I/O instruction arrives as a one-cycle strobe that carries the device code, a six-bit pulse field and the 18-bit accumulator. Depending on the code and the pulse bits, the block loads the memory-address register, latches whether the next transfer reads or writes, loads the sector address, runs skip tests on the done and error flags, clears those flags, or asks the engine to start a sector transfer.

The engine handles rotational timing and moves the words. When a sector finishes, it pulses a completion input, optionally with an error. The block then sets done (and error if flagged) and advances its address registers to the next sector. The done flag drives the bit this controller contributes to the processor's I/O status word. The accumulator passes through unchanged, and the only thing the block adds to it is the skip request.

Top module: `drum_iot_decoder`

## Requirements
- R1: On device code DEV_BASE, a pulse whose bits masked with octal 027 equal octal 06 loads the memory address from accumulator bits 15:0 and latches the function from pulse bit 5 (0 = read, 1 = write), visible on the outputs in the cycle after the strobe.
- R2: On device code DEV_BASE+1, pulse bit 0 asserts skip_o during the strobe cycle when the done flag is set.
- R3: On device code DEV_BASE+1, pulse bit 1 clears the done and error flags at the next clock edge.
- R4: On device code DEV_BASE+1, pulse bit 2 loads the sector address from accumulator bits 8:0 and raises start_o for exactly the following cycle, with the new sector on start_sector_o.
- R5: On device code DEV_BASE+2, pulse bit 0 asserts skip_o during the strobe cycle when the error flag is clear.
- R6: On device code DEV_BASE+2, pulse bit 2 clears done and error and raises start_o in the following cycle with the sector address unchanged.
- R7: A completion pulse sets done, and sets error when its error input is high. It advances the sector address by one modulo 512 and the memory address by WORDS_PER_SEC modulo 65536. A completion outweighs a flag clear in the same cycle, with error then taken from the completion alone. An address load in the same cycle outweighs the advance of that register.
- R8: An active-low reset clears the sector address, the memory address, the function, done, error and any pending start strobe.
- R9: ac_o always equals ac_i. skip_o is low without a strobe. Strobes on other device codes, and pulse bits that no rule above names, change no output or register.
- R10: status_o equals the done flag at all times.
- R11: A skip test reads the flags as they stood before the strobe, even when the same pulse also clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| iot_valid_i | input | 1 | One-cycle I/O instruction strobe |
| dev_sel_i | input | 6 | Device-select code of the instruction |
| pulse_i | input | 6 | Pulse field of the instruction |
| ac_i | input | 18 | Accumulator from the processor |
| ac_o | output | 18 | Accumulator returned to the processor |
| skip_o | output | 1 | Skip request for the current strobe |
| status_o | output | 1 | Done bit for the I/O status word |
| start_o | output | 1 | One-cycle transfer start request |
| start_write_o | output | 1 | Latched function, 1 = write |
| start_sector_o | output | 9 | Current sector address |
| start_maddr_o | output | 16 | Current memory address |
| xfer_done_i | input | 1 | Sector transfer finished |
| xfer_err_i | input | 1 | Finished transfer had an error |

## Verification
A wrong flag shows up at the ports right away. It appears on status_o one cycle after the event, and in the skip answer to the very next test on either device code, so a bad clear or set priority is caught within a couple of cycles. A corrupted address register is continuously visible on start_sector_o and start_maddr_o. Its advance is checked at the exact completion edge, including the 511-to-0 and memory-address wrap cases. A misdecoded pulse either produces a start strobe one cycle late or missing, or changes a register that a strobe on a foreign code should leave unchanged. The bench compares every one of these each cycle against a model driven by random and directed strobes.

// File: rtl/drum_iot_pkg.sv
package drum_iot_pkg;
  typedef struct packed {
    logic load_ma;
    logic fn_write;
    logic load_sec;
    logic clr_flags;
    logic start;
    logic skip_done;
    logic skip_noerr;
  } iot_cmd_t;

  localparam int unsigned NUM_CODES = 3;
  localparam int unsigned FN_BIT    = 5;
endpackage

// File: rtl/drum_iot_dec.sv
module drum_iot_dec
  import drum_iot_pkg::*;
#(
  parameter int unsigned DEV_W    = 6,
  parameter int unsigned PULSE_W  = 6,
  parameter int unsigned DEV_BASE = 6'o60
) (
  input  logic               valid_i,
  input  logic [DEV_W-1:0]   dev_i,
  input  logic [PULSE_W-1:0] pulse_i,
  output iot_cmd_t           cmd_o
);
  localparam logic [PULSE_W-1:0] LD_MASK = PULSE_W'(6'o27);
  localparam logic [PULSE_W-1:0] LD_CODE = PULSE_W'(6'o06);

  logic [NUM_CODES-1:0] sel;

  for (genvar k = 0; k < NUM_CODES; k++) begin : g_sel
    assign sel[k] = valid_i && (dev_i == DEV_W'(DEV_BASE + k));
  end

  always_comb begin
    cmd_o            = '0;
    cmd_o.load_ma    = sel[0] && ((pulse_i & LD_MASK) == LD_CODE);
    cmd_o.fn_write   = pulse_i[FN_BIT];
    cmd_o.skip_done  = sel[1] && pulse_i[0];
    cmd_o.load_sec   = sel[1] && pulse_i[2];
    // restart on third code clears flags too
    cmd_o.clr_flags  = (sel[1] && pulse_i[1]) || (sel[2] && pulse_i[2]);
    cmd_o.start      = (sel[1] || sel[2]) && pulse_i[2];
    cmd_o.skip_noerr = sel[2] && pulse_i[0];
  end
endmodule

// File: rtl/drum_iot_addr.sv
module drum_iot_addr #(
  parameter int unsigned AC_W          = 18,
  parameter int unsigned MA_W          = 16,
  parameter int unsigned SEC_W         = 9,
  parameter int unsigned WORDS_PER_SEC = 256
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_ma_i,
  input  logic             fn_write_i,
  input  logic             load_sec_i,
  input  logic             advance_i,
  input  logic [AC_W-1:0]  ac_i,
  output logic [MA_W-1:0]  ma_o,
  output logic [SEC_W-1:0] sec_o,
  output logic             write_o
);
  localparam logic [MA_W-1:0]  MA_STEP  = MA_W'(WORDS_PER_SEC);
  localparam logic [SEC_W-1:0] SEC_STEP = SEC_W'(1);

  logic [MA_W-1:0]  ma_q;
  logic [SEC_W-1:0] sec_q;
  logic             wr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ma_q  <= '0;
      sec_q <= '0;
      wr_q  <= 1'b0;
    end else begin
      if (load_ma_i) begin
        ma_q <= ac_i[MA_W-1:0];
        wr_q <= fn_write_i;
      end else if (advance_i) begin
        ma_q <= ma_q + MA_STEP;
      end
      if (load_sec_i)     sec_q <= ac_i[SEC_W-1:0];
      else if (advance_i) sec_q <= sec_q + SEC_STEP;
    end
  end

  assign ma_o    = ma_q;
  assign sec_o   = sec_q;
  assign write_o = wr_q;
endmodule

// File: rtl/drum_iot_flags.sv
module drum_iot_flags (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic cmpl_i,
  input  logic cmpl_err_i,
  input  logic start_i,
  output logic done_o,
  output logic err_o,
  output logic start_o
);
  logic done_q, err_q, start_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      start_q <= 1'b0;
    end else begin
      start_q <= start_i;
      // completion outranks a same-cycle clear
      if (cmpl_i) begin
        done_q <= 1'b1;
        err_q  <= clr_i ? cmpl_err_i : (err_q | cmpl_err_i);
      end else if (clr_i) begin
        done_q <= 1'b0;
        err_q  <= 1'b0;
      end
    end
  end

  assign done_o  = done_q;
  assign err_o   = err_q;
  assign start_o = start_q;
endmodule

// File: rtl/drum_iot_decoder.sv
module drum_iot_decoder
  import drum_iot_pkg::*;
#(
  parameter int unsigned DEV_W         = 6,
  parameter int unsigned PULSE_W       = 6,
  parameter int unsigned DEV_BASE      = 6'o60,
  parameter int unsigned AC_W          = 18,
  parameter int unsigned MA_W          = 16,
  parameter int unsigned SEC_W         = 9,
  parameter int unsigned WORDS_PER_SEC = 256
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               iot_valid_i,
  input  logic [DEV_W-1:0]   dev_sel_i,
  input  logic [PULSE_W-1:0] pulse_i,
  input  logic [AC_W-1:0]    ac_i,
  output logic [AC_W-1:0]    ac_o,
  output logic               skip_o,
  output logic               status_o,
  output logic               start_o,
  output logic               start_write_o,
  output logic [SEC_W-1:0]   start_sector_o,
  output logic [MA_W-1:0]    start_maddr_o,
  input  logic               xfer_done_i,
  input  logic               xfer_err_i
);
  iot_cmd_t cmd;
  logic     done, err;

  drum_iot_dec #(
    .DEV_W(DEV_W), .PULSE_W(PULSE_W), .DEV_BASE(DEV_BASE)
  ) u_dec (
    .valid_i(iot_valid_i), .dev_i(dev_sel_i), .pulse_i(pulse_i), .cmd_o(cmd)
  );

  drum_iot_addr #(
    .AC_W(AC_W), .MA_W(MA_W), .SEC_W(SEC_W), .WORDS_PER_SEC(WORDS_PER_SEC)
  ) u_addr (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .load_ma_i(cmd.load_ma), .fn_write_i(cmd.fn_write),
    .load_sec_i(cmd.load_sec), .advance_i(xfer_done_i), .ac_i(ac_i),
    .ma_o(start_maddr_o), .sec_o(start_sector_o), .write_o(start_write_o)
  );

  drum_iot_flags u_flags (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .clr_i(cmd.clr_flags), .cmpl_i(xfer_done_i), .cmpl_err_i(xfer_err_i),
    .start_i(cmd.start),
    .done_o(done), .err_o(err), .start_o(start_o)
  );

  // skip reads pre-edge flags
  assign skip_o   = (cmd.skip_done && done) || (cmd.skip_noerr && !err);
  assign ac_o     = ac_i;
  assign status_o = done;
endmodule

// File: rtl/drum_iot_decoder_chk.sv
module drum_iot_decoder_chk #(
  parameter int unsigned DEV_W    = 6,
  parameter int unsigned PULSE_W  = 6,
  parameter int unsigned DEV_BASE = 6'o60,
  parameter int unsigned AC_W     = 18,
  parameter int unsigned MA_W     = 16,
  parameter int unsigned SEC_W    = 9
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               iot_valid_i,
  input logic [DEV_W-1:0]   dev_sel_i,
  input logic [PULSE_W-1:0] pulse_i,
  input logic [AC_W-1:0]    ac_i,
  input logic               skip_o,
  input logic               status_o,
  input logic               start_o,
  input logic               start_write_o,
  input logic [SEC_W-1:0]   start_sector_o,
  input logic [MA_W-1:0]    start_maddr_o,
  input logic               xfer_done_i
);
  logic c0, c1, c2;
  assign c0 = iot_valid_i && (dev_sel_i == DEV_W'(DEV_BASE));
  assign c1 = iot_valid_i && (dev_sel_i == DEV_W'(DEV_BASE + 1));
  assign c2 = iot_valid_i && (dev_sel_i == DEV_W'(DEV_BASE + 2));

  assert_skip_needs_strobe_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !iot_valid_i |-> !skip_o);

  assert_load_maddr_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (c0 && ((pulse_i & PULSE_W'(6'o27)) == PULSE_W'(6'o06)))
    |=> (start_maddr_o == $past(ac_i[MA_W-1:0])) && (start_write_o == $past(pulse_i[5])));

  assert_sector_start_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (c1 && pulse_i[2]) |=> start_o && (start_sector_o == $past(ac_i[SEC_W-1:0])));

  assert_restart_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (c2 && pulse_i[2] && !xfer_done_i)
    |=> start_o && !status_o && (start_sector_o == $past(start_sector_o)));

  assert_done_sets_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_done_i |=> status_o);

  assert_clear_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (c1 && pulse_i[1] && !xfer_done_i) |=> !status_o);
endmodule

bind drum_iot_decoder drum_iot_decoder_chk #(
  .DEV_W(DEV_W), .PULSE_W(PULSE_W), .DEV_BASE(DEV_BASE),
  .AC_W(AC_W), .MA_W(MA_W), .SEC_W(SEC_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .iot_valid_i(iot_valid_i),
  .dev_sel_i(dev_sel_i), .pulse_i(pulse_i), .ac_i(ac_i),
  .skip_o(skip_o), .status_o(status_o), .start_o(start_o),
  .start_write_o(start_write_o), .start_sector_o(start_sector_o),
  .start_maddr_o(start_maddr_o), .xfer_done_i(xfer_done_i)
);

// File: tb/tb_drum_iot_decoder.sv
`timescale 1ns/1ps
module tb_drum_iot_decoder;
  localparam logic [5:0] B = 6'o60;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid = 1'b0;
  logic [5:0]  dev = '0;
  logic [5:0]  pulse = '0;
  logic [17:0] ac = '0;
  logic        xd = 1'b0, xe = 1'b0;
  logic [17:0] ac_o;
  logic        skip_o, status_o, start_o, wr_o;
  logic [8:0]  sec_o;
  logic [15:0] ma_o;

  always #2 clk = ~clk;

  drum_iot_decoder dut (
    .clk_i(clk), .rst_ni(rst_ni), .iot_valid_i(valid), .dev_sel_i(dev),
    .pulse_i(pulse), .ac_i(ac), .ac_o(ac_o), .skip_o(skip_o),
    .status_o(status_o), .start_o(start_o), .start_write_o(wr_o),
    .start_sector_o(sec_o), .start_maddr_o(ma_o),
    .xfer_done_i(xd), .xfer_err_i(xe)
  );

  int n_chk = 0, n_fail = 0;
  logic [15:0] m_ma;
  logic [8:0]  m_sec;
  logic        m_wr, m_done, m_err, m_start;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  function automatic logic exp_skip(logic v, logic [5:0] d, logic [5:0] p);
    return v && ((d == B + 6'd1 && p[0] && m_done) || (d == B + 6'd2 && p[0] && !m_err));
  endfunction

  task automatic model_reset();
    m_ma = '0; m_sec = '0; m_wr = 1'b0; m_done = 1'b0; m_err = 1'b0; m_start = 1'b0;
  endtask

  task automatic model_edge(logic v, logic [5:0] d, logic [5:0] p, logic [17:0] a,
                            logic cd, logic ce);
    logic ld_ma, ld_sec, clr;
    ld_ma  = v && d == B && ((p & 6'o27) == 6'o06);
    ld_sec = v && d == B + 6'd1 && p[2];
    clr    = v && ((d == B + 6'd1 && p[1]) || (d == B + 6'd2 && p[2]));
    m_start = v && (d == B + 6'd1 || d == B + 6'd2) && p[2];
    if (ld_ma) begin m_ma = a[15:0]; m_wr = p[5]; end
    else if (cd) m_ma = m_ma + 16'd256;
    if (ld_sec) m_sec = a[8:0];
    else if (cd) m_sec = m_sec + 9'd1;
    if (cd) begin m_done = 1'b1; m_err = clr ? ce : (m_err | ce); end
    else if (clr) begin m_done = 1'b0; m_err = 1'b0; end
  endtask

  task automatic check_regs(input string tag);
    chk({tag, " R10 status"}, status_o, m_done);
    chk({tag, " start"}, start_o, m_start);
    chk({tag, " sector"}, sec_o, m_sec);
    chk({tag, " maddr"}, ma_o, m_ma);
    chk({tag, " fn"}, wr_o, m_wr);
  endtask

  task automatic step(input string tag, input logic v, input logic [5:0] d,
                      input logic [5:0] p, input logic [17:0] a,
                      input logic cd = 1'b0, input logic ce = 1'b0);
    @(negedge clk);
    valid = v; dev = d; pulse = p; ac = a; xd = cd; xe = ce;
    #1;
    chk({tag, " R9 ac pass"}, ac_o, a);
    chk({tag, " R11 skip"}, skip_o, exp_skip(v, d, p));
    @(posedge clk);
    model_edge(v, d, p, a, cd, ce);
    #1;
    valid = 1'b0; xd = 1'b0; xe = 1'b0;
    check_regs(tag);
  endtask

  initial begin
    #(4 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'd4711));
    model_reset();
    #5;
    chk("R8 reset status", status_o, 1'b0);
    chk("R8 reset start", start_o, 1'b0);
    chk("R8 reset sector", sec_o, 9'd0);
    chk("R8 reset maddr", ma_o, 16'd0);
    @(negedge clk); rst_ni = 1'b1;

    // R1: load ma with write function, and bit 3 don't-care
    step("R1 load write", 1'b1, B, 6'o46, 18'o712345);
    step("R1 load read", 1'b1, B, 6'o16, 18'o654321);
    step("R9 no load bit0", 1'b1, B, 6'o07, 18'o111111);
    // R5 skip when no error
    step("R5 skip noerr", 1'b1, B + 6'd2, 6'o01, 18'd0);
    // R4 load sector, start
    step("R4 load sector", 1'b1, B + 6'd1, 6'o04, 18'o777777);
    // R7 completion with error, wraps sector 511->0
    step("R7 cmpl err", 1'b0, B, 6'o00, 18'd0, 1'b1, 1'b1);
    step("R2 skip done", 1'b1, B + 6'd1, 6'o01, 18'd0);
    step("R5 no skip err", 1'b1, B + 6'd2, 6'o01, 18'd0);
    // R11 skip and clear in one pulse
    step("R3 skip+clear", 1'b1, B + 6'd1, 6'o03, 18'd0);
    step("R2 no skip", 1'b1, B + 6'd1, 6'o01, 18'd0);
    // R7 memory-address wrap
    step("R1 ma near top", 1'b1, B, 6'o06, 18'o177600);
    step("R7 ma wrap", 1'b0, B, 6'o00, 18'd0, 1'b1, 1'b0);
    // R7 completion beats clear
    step("R7 cmpl vs clr", 1'b1, B + 6'd1, 6'o02, 18'd0, 1'b1, 1'b1);
    // R6 restart keeps sector, clears flags
    step("R6 restart", 1'b1, B + 6'd2, 6'o04, 18'o000123);
    // R9 foreign code
    step("R9 foreign", 1'b1, 6'o12, 6'o77, 18'o000321);

    for (int i = 0; i < 400; i++) begin
      int r;
      logic [5:0] d;
      r = $urandom % 4;
      d = (r < 3) ? (B + 6'(r)) : 6'(($urandom % 40));
      step("RND", ($urandom % 4) != 0, d, 6'($urandom), 18'($urandom),
           ($urandom % 6) == 0, ($urandom % 3) == 0);
    end

    // R8 mid-run reset
    step("R4 pre-reset", 1'b1, B + 6'd1, 6'o04, 18'o000055, 1'b1, 1'b1);
    @(negedge clk); rst_ni = 1'b0; #1;
    model_reset();
    check_regs("R8 async reset");
    @(negedge clk); rst_ni = 1'b1;
    step("R8 after reset", 1'b0, B, 6'o00, 18'd0);
    finish_run();
  end
endmodule